// File: doc/BRIEF.md
# Four-Channel DMA Host Register File

This block is the processor-facing register file of a four-channel DMA controller. A host reaches it over an 8-bit I/O bus with a 5-bit port offset. Behind that narrow bus each channel keeps a 16-bit base and current transfer address and a 16-bit base and current transfer count. A single byte-pointer flip-flop, shared by every channel, decides whether an access to one of these registers hits the low or the high byte. The host loads the low byte first and then the high byte.

Beside the channel registers the block holds the channel masks, the per-channel mode bytes, a command byte, a software request byte and a status byte. It also decodes the clear-pointer and master-clear strobes. The transfer engine reads all of this state as flat output vectors. It feeds back current-register updates, terminal-count pulses and its temporary data byte.

Top module: `dma_regfile`

## Requirements
- R1: After reset every channel is masked (`ch_mask` = 4'hF), `ctl_cmd`, `ch_req` and all status flags are 0, all address, count and mode registers are 0, and the byte pointer selects the low byte.
- R2: Offset 2n is channel n's address port and offset 2n+1 its count port (n = 0..3). A write stores the data byte into both the base and the current copy, in the byte chosen by the pointer: low when the pointer is clear, high when it is set.
- R3: Every read or write to offsets 0x00 to 0x07 toggles the byte pointer, whichever channel or register it hits, so a low-byte access to one register makes the next access to any register hit its high byte.
- R4: A write of any value to offset 0x0C forces the byte pointer back to the low byte.
- R5: A read of an address or count port returns the byte of the current copy that the pointer selects. Reads of ports that are only written, and of offsets 0x10 to 0x1F, return 0x00, and so does `bus_rdata` when no read is strobed. When `bus_wr` and `bus_rd` are strobed together, the cycle is a write.
- R6: A write to offset 0x0A selects a channel with bits 1:0 and sets that channel's mask when bit 2 is 1 or clears it when bit 2 is 0. The other masks are unchanged.
- R7: A write of any value to offset 0x0E clears all four masks. A write to offset 0x0F loads data bits 3:0 into masks 3:0.
- R8: A write to offset 0x0B selects a channel with bits 1:0 and stores data bits 7:2 in that channel's 6-bit mode field, `ch_mode[6n+5:6n]`. Field bit 2 (data bit 4) is the auto-initialise enable.
- R9: A write to offset 0x08 loads `ctl_cmd`. A write to offset 0x09 selects a channel with bits 1:0 and sets (bit 2 = 1) or clears (bit 2 = 0) that channel's bit of `ch_req`.
- R10: A read of offset 0x08 returns {`ch_req`[3:0], tc flags[3:0]}. A pulse on `eng_tc[n]` sets tc flag n. The status read clears the flags at the end of its cycle, but a pulse in that same cycle leaves its flag set.
- R11: A write to offset 0x0D masks all channels and clears `ctl_cmd`, `ch_req`, the tc flags and the byte pointer. Address, count and mode registers keep their values. A read of offset 0x0D returns `eng_temp`.
- R12: `ch_len[17n+16:17n]` is the number of transfers that channel n's current count stands for, the count plus one: 0x0000 gives 1 and 0xFFFF gives 65536.
- R13: `eng_upd_valid` loads the current address and count of channel `eng_upd_ch`. `eng_tc[n]` on a channel whose auto-initialise bit is set reloads both current copies from the base copies. The reload takes priority over an update, and the byte of a bus write in the same cycle takes priority over both. Base copies change only through bus writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Bus cycle select |
| bus_wr | input | 1 | Write strobe (qualified by bus_cs) |
| bus_rd | input | 1 | Read strobe (qualified by bus_cs) |
| bus_addr | input | 5 | Port offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset and state |
| eng_upd_valid | input | 1 | Engine writes a channel's current registers |
| eng_upd_ch | input | 2 | Channel the engine updates |
| eng_upd_addr | input | 16 | New current address |
| eng_upd_cnt | input | 16 | New current count |
| eng_tc | input | 4 | Terminal-count pulse per channel |
| eng_temp | input | 8 | Engine temporary data byte |
| ch_mask | output | 4 | Channel mask bits |
| ch_mode | output | 24 | Mode fields, 6 bits per channel |
| ch_base_addr | output | 64 | Base addresses, 16 bits per channel |
| ch_cur_addr | output | 64 | Current addresses |
| ch_base_cnt | output | 64 | Base counts |
| ch_cur_cnt | output | 64 | Current counts |
| ch_len | output | 68 | Transfer totals, 17 bits per channel |
| ctl_cmd | output | 8 | Command byte |
| ch_req | output | 4 | Software request bits |

## Verification
Every register effect of a bus or engine strobe shows on the outputs one clock after the edge that samples the strobe. `bus_rdata` is combinational and valid in the cycle the read is strobed, while the pointer toggle and the tc-flag clear that the read causes land on that cycle's closing edge. The bench drives strobes on the falling edge. Its behavioural model applies each strobe at the rising edge, just as the design does, and compares every output 2 ns later. It samples directed read data 2 ns after driving, before the edge that moves the pointer.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam int NCH    = 4;
  localparam int CH_W   = $clog2(NCH);
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int OFF_W  = 5;
  localparam int MODE_W = BYTE_W - CH_W;
  localparam int LEN_W  = REG_W + 1;
  localparam int AUTO_BIT = 4 - CH_W;

  localparam logic [OFF_W-1:0] OFF_CMD_STAT = 5'h08;
  localparam logic [OFF_W-1:0] OFF_REQ      = 5'h09;
  localparam logic [OFF_W-1:0] OFF_SMASK    = 5'h0A;
  localparam logic [OFF_W-1:0] OFF_MODE     = 5'h0B;
  localparam logic [OFF_W-1:0] OFF_CLRPTR   = 5'h0C;
  localparam logic [OFF_W-1:0] OFF_MCLR_TMP = 5'h0D;
  localparam logic [OFF_W-1:0] OFF_CLRMASK  = 5'h0E;
  localparam logic [OFF_W-1:0] OFF_ALLMASK  = 5'h0F;

  typedef struct packed {
    logic            chreg_acc;
    logic            chreg_wr;
    logic [CH_W-1:0] sel_ch;
    logic            sel_cnt;
    logic            cmd_wr;
    logic            stat_rd;
    logic            req_wr;
    logic            smask_wr;
    logic            mode_wr;
    logic            clrptr_wr;
    logic            mclr_wr;
    logic            temp_rd;
    logic            clrmask_wr;
    logic            allmask_wr;
  } dec_t;

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [REG_W-1:0] v,
                                                  input logic hi);
    return hi ? v[REG_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  function automatic logic [REG_W-1:0] put_byte(input logic [REG_W-1:0] v,
                                                input logic [BYTE_W-1:0] b,
                                                input logic hi);
    return hi ? {b, v[BYTE_W-1:0]} : {v[REG_W-1:BYTE_W], b};
  endfunction

  function automatic logic [LEN_W-1:0] xfer_len(input logic [REG_W-1:0] cnt);
    return {1'b0, cnt} + LEN_W'(1);
  endfunction
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
  import dma_rf_pkg::*;
(
  input  logic             bus_cs,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [OFF_W-1:0] bus_addr,
  output dec_t             dec_o
);
  logic wr_q, rd_q;
  assign wr_q = bus_cs & bus_wr;
  assign rd_q = bus_cs & bus_rd & ~bus_wr;

  always_comb begin
    dec_o         = '0;
    dec_o.sel_ch  = bus_addr[CH_W:1];
    dec_o.sel_cnt = bus_addr[0];
    if (bus_addr[OFF_W-1:CH_W+1] == '0) begin
      dec_o.chreg_acc = wr_q | rd_q;
      dec_o.chreg_wr  = wr_q;
    end else begin
      case (bus_addr)
        OFF_CMD_STAT: begin dec_o.cmd_wr = wr_q; dec_o.stat_rd = rd_q; end
        OFF_REQ:      dec_o.req_wr     = wr_q;
        OFF_SMASK:    dec_o.smask_wr   = wr_q;
        OFF_MODE:     dec_o.mode_wr    = wr_q;
        OFF_CLRPTR:   dec_o.clrptr_wr  = wr_q;
        OFF_MCLR_TMP: begin dec_o.mclr_wr = wr_q; dec_o.temp_rd = rd_q; end
        OFF_CLRMASK:  dec_o.clrmask_wr = wr_q;
        OFF_ALLMASK:  dec_o.allmask_wr = wr_q;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_rf_ctrl.sv
module dma_rf_ctrl
  import dma_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dec_t              dec,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [NCH-1:0]    eng_tc,
  output logic              ptr_hi,
  output logic [NCH-1:0]    mask,
  output logic [BYTE_W-1:0] cmd,
  output logic [NCH-1:0]    req,
  output logic [NCH-1:0]    tc_flags
);
  logic              ptr_n;
  logic [NCH-1:0]    mask_n, req_n, tc_n;
  logic [BYTE_W-1:0] cmd_n;
  logic [CH_W-1:0]   wsel;
  assign wsel = wdata[CH_W-1:0];

  always_comb begin
    ptr_n  = ptr_hi;
    mask_n = mask;
    req_n  = req;
    cmd_n  = cmd;
    tc_n   = (dec.stat_rd ? '0 : tc_flags) | eng_tc;
    if (dec.clrptr_wr)      ptr_n = 1'b0;
    else if (dec.chreg_acc) ptr_n = ~ptr_hi;
    if (dec.smask_wr)   mask_n[wsel] = wdata[2];
    if (dec.clrmask_wr) mask_n = '0;
    if (dec.allmask_wr) mask_n = wdata[NCH-1:0];
    if (dec.req_wr)     req_n[wsel] = wdata[2];
    if (dec.cmd_wr)     cmd_n = wdata;
    if (dec.mclr_wr) begin
      ptr_n  = 1'b0;
      mask_n = '1;
      req_n  = '0;
      cmd_n  = '0;
      tc_n   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_hi   <= 1'b0;
      mask     <= '1;
      req      <= '0;
      cmd      <= '0;
      tc_flags <= '0;
    end else begin
      ptr_hi   <= ptr_n;
      mask     <= mask_n;
      req      <= req_n;
      cmd      <= cmd_n;
      tc_flags <= tc_n;
    end
  end
endmodule

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
  import dma_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic              cnt_wr,
  input  logic              mode_wr,
  input  logic              ptr_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              upd_hit,
  input  logic [REG_W-1:0]  upd_addr,
  input  logic [REG_W-1:0]  upd_cnt,
  input  logic              tc,
  output logic [REG_W-1:0]  base_addr,
  output logic [REG_W-1:0]  cur_addr,
  output logic [REG_W-1:0]  base_cnt,
  output logic [REG_W-1:0]  cur_cnt,
  output logic [MODE_W-1:0] mode,
  output logic [LEN_W-1:0]  len
);
  logic [REG_W-1:0] ca_n, cc_n, ba_n, bc_n;
  logic             reload;
  assign reload = tc & mode[AUTO_BIT];

  always_comb begin
    ba_n = base_addr;
    bc_n = base_cnt;
    ca_n = cur_addr;
    cc_n = cur_cnt;
    if (reload) begin
      ca_n = base_addr;
      cc_n = base_cnt;
    end else if (upd_hit) begin
      ca_n = upd_addr;
      cc_n = upd_cnt;
    end
    if (addr_wr) begin
      ba_n = put_byte(base_addr, wdata, ptr_hi);
      ca_n = put_byte(ca_n, wdata, ptr_hi);
    end
    if (cnt_wr) begin
      bc_n = put_byte(base_cnt, wdata, ptr_hi);
      cc_n = put_byte(cc_n, wdata, ptr_hi);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode      <= '0;
    end else begin
      base_addr <= ba_n;
      base_cnt  <= bc_n;
      cur_addr  <= ca_n;
      cur_cnt   <= cc_n;
      if (mode_wr) mode <= wdata[BYTE_W-1:CH_W];
    end
  end

  assign len = xfer_len(cur_cnt);
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_cs,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [OFF_W-1:0]      bus_addr,
  input  logic [BYTE_W-1:0]     bus_wdata,
  output logic [BYTE_W-1:0]     bus_rdata,
  input  logic                  eng_upd_valid,
  input  logic [CH_W-1:0]       eng_upd_ch,
  input  logic [REG_W-1:0]      eng_upd_addr,
  input  logic [REG_W-1:0]      eng_upd_cnt,
  input  logic [NCH-1:0]        eng_tc,
  input  logic [BYTE_W-1:0]     eng_temp,
  output logic [NCH-1:0]        ch_mask,
  output logic [NCH*MODE_W-1:0] ch_mode,
  output logic [NCH*REG_W-1:0]  ch_base_addr,
  output logic [NCH*REG_W-1:0]  ch_cur_addr,
  output logic [NCH*REG_W-1:0]  ch_base_cnt,
  output logic [NCH*REG_W-1:0]  ch_cur_cnt,
  output logic [NCH*LEN_W-1:0]  ch_len,
  output logic [BYTE_W-1:0]     ctl_cmd,
  output logic [NCH-1:0]        ch_req
);
  dec_t           dec;
  logic           ptr_hi;
  logic [NCH-1:0] tc_flags;

  // Named events for the bound checker
  logic ev_chreg_acc, ev_chreg_wr, ev_clrptr, ev_mclr, ev_smask, ev_allmask, ev_cmd_wr;
  assign ev_chreg_acc = dec.chreg_acc;
  assign ev_chreg_wr  = dec.chreg_wr;
  assign ev_clrptr    = dec.clrptr_wr;
  assign ev_mclr      = dec.mclr_wr;
  assign ev_smask     = dec.smask_wr;
  assign ev_allmask   = dec.allmask_wr;
  assign ev_cmd_wr    = dec.cmd_wr;

  dma_rf_decode u_dec (
    .bus_cs   (bus_cs),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .dec_o    (dec)
  );

  dma_rf_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (dec),
    .wdata    (bus_wdata),
    .eng_tc   (eng_tc),
    .ptr_hi   (ptr_hi),
    .mask     (ch_mask),
    .cmd      (ctl_cmd),
    .req      (ch_req),
    .tc_flags (tc_flags)
  );

  logic [REG_W-1:0] cur_a [NCH];
  logic [REG_W-1:0] cur_c [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit_reg, addr_wr, cnt_wr, mode_wr, upd_hit;
    assign hit_reg = dec.chreg_wr && (dec.sel_ch == CH_W'(g));
    assign addr_wr = hit_reg && !dec.sel_cnt;
    assign cnt_wr  = hit_reg && dec.sel_cnt;
    assign mode_wr = dec.mode_wr && (bus_wdata[CH_W-1:0] == CH_W'(g));
    assign upd_hit = eng_upd_valid && (eng_upd_ch == CH_W'(g));

    dma_rf_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_wr   (addr_wr),
      .cnt_wr    (cnt_wr),
      .mode_wr   (mode_wr),
      .ptr_hi    (ptr_hi),
      .wdata     (bus_wdata),
      .upd_hit   (upd_hit),
      .upd_addr  (eng_upd_addr),
      .upd_cnt   (eng_upd_cnt),
      .tc        (eng_tc[g]),
      .base_addr (ch_base_addr[g*REG_W +: REG_W]),
      .cur_addr  (cur_a[g]),
      .base_cnt  (ch_base_cnt[g*REG_W +: REG_W]),
      .cur_cnt   (cur_c[g]),
      .mode      (ch_mode[g*MODE_W +: MODE_W]),
      .len       (ch_len[g*LEN_W +: LEN_W])
    );

    assign ch_cur_addr[g*REG_W +: REG_W] = cur_a[g];
    assign ch_cur_cnt[g*REG_W +: REG_W]  = cur_c[g];
  end

  always_comb begin
    bus_rdata = '0;
    if (dec.chreg_acc && !dec.chreg_wr)
      bus_rdata = pick_byte(dec.sel_cnt ? cur_c[dec.sel_ch] : cur_a[dec.sel_ch], ptr_hi);
    else if (dec.stat_rd)
      bus_rdata = {ch_req, tc_flags};
    else if (dec.temp_rd)
      bus_rdata = eng_temp;
  end
endmodule

// File: rtl/dma_regfile_checker.sv
module dma_regfile_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_chreg_acc,
  input logic        ev_chreg_wr,
  input logic        ev_clrptr,
  input logic        ev_mclr,
  input logic        ev_smask,
  input logic        ev_allmask,
  input logic        ev_cmd_wr,
  input logic        ptr_hi,
  input logic [7:0]  bus_wdata,
  input logic [3:0]  ch_mask,
  input logic [7:0]  ctl_cmd,
  input logic [3:0]  ch_req,
  input logic [63:0] ch_base_addr,
  input logic [63:0] ch_base_cnt
);
  assert_ptr_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chreg_acc |=> ptr_hi != $past(ptr_hi));

  assert_clrptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clrptr |=> !ptr_hi);

  assert_smask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_smask |=> ch_mask[$past(bus_wdata[1:0])] == $past(bus_wdata[2]));

  assert_allmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_allmask |=> ch_mask == $past(bus_wdata[3:0]));

  assert_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_wr |=> ctl_cmd == $past(bus_wdata));

  assert_mclr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mclr |=> (ch_mask == 4'hF) && (ctl_cmd == 8'h00) && (ch_req == 4'h0) && !ptr_hi);

  assert_base_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_chreg_wr |=> $stable(ch_base_addr) && $stable(ch_base_cnt));
endmodule

bind dma_regfile dma_regfile_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_chreg_acc (ev_chreg_acc),
  .ev_chreg_wr  (ev_chreg_wr),
  .ev_clrptr    (ev_clrptr),
  .ev_mclr      (ev_mclr),
  .ev_smask     (ev_smask),
  .ev_allmask   (ev_allmask),
  .ev_cmd_wr    (ev_cmd_wr),
  .ptr_hi       (ptr_hi),
  .bus_wdata    (bus_wdata),
  .ch_mask      (ch_mask),
  .ctl_cmd      (ctl_cmd),
  .ch_req       (ch_req),
  .ch_base_addr (ch_base_addr),
  .ch_base_cnt  (ch_base_cnt)
);

// File: tb/dma_regfile_bench.sv
`timescale 1ns/1ps
module dma_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs = 0, bus_wr = 0, bus_rd = 0;
  logic [4:0]  bus_addr = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic        eng_upd_valid = 0;
  logic [1:0]  eng_upd_ch = 0;
  logic [15:0] eng_upd_addr = 0, eng_upd_cnt = 0;
  logic [3:0]  eng_tc = 0;
  logic [7:0]  eng_temp = 0;
  logic [3:0]  ch_mask;
  logic [23:0] ch_mode;
  logic [63:0] ch_base_addr, ch_cur_addr, ch_base_cnt, ch_cur_cnt;
  logic [67:0] ch_len;
  logic [7:0]  ctl_cmd;
  logic [3:0]  ch_req;

  always #4 clk = ~clk;

  dma_regfile u_dma_regfile (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [67:0] act, input logic [67:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_ba[4], m_ca[4], m_bc[4], m_cc[4];
  logic [5:0]  m_md[4];
  logic [3:0]  m_mask = 4'hF, m_req = 0, m_tc = 0;
  logic [7:0]  m_cmd = 0;
  bit          m_ptr = 0;
  bit          m_w, m_r;
  int          m_a, m_c;

  function automatic logic [7:0] exp_rdata();
    int a = bus_addr;
    bit r = bus_cs && bus_rd && !bus_wr;
    logic [15:0] v;
    if (!r) return 8'h00;
    if (a < 8) begin
      v = a[0] ? m_cc[a >> 1] : m_ca[a >> 1];
      return m_ptr ? v[15:8] : v[7:0];
    end
    if (a == 8)  return {m_req, m_tc};
    if (a == 13) return eng_temp;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_md[i] = 0;
      end
      m_mask = 4'hF; m_req = 0; m_tc = 0; m_cmd = 0; m_ptr = 0;
    end else begin
      m_w = bus_cs && bus_wr;
      m_r = bus_cs && bus_rd && !bus_wr;
      m_a = bus_addr;
      for (int i = 0; i < 4; i++) begin
        if (eng_tc[i] && m_md[i][2]) begin m_ca[i] = m_ba[i]; m_cc[i] = m_bc[i]; end
        else if (eng_upd_valid && eng_upd_ch == i) begin
          m_ca[i] = eng_upd_addr; m_cc[i] = eng_upd_cnt;
        end
      end
      if (m_r && m_a == 8) m_tc = 0;
      m_tc = m_tc | eng_tc;
      if (m_a < 8 && (m_w || m_r)) begin
        if (m_w) begin
          m_c = m_a >> 1;
          if (m_a % 2 == 1) begin
            if (m_ptr) begin m_bc[m_c][15:8] = bus_wdata; m_cc[m_c][15:8] = bus_wdata; end
            else       begin m_bc[m_c][7:0]  = bus_wdata; m_cc[m_c][7:0]  = bus_wdata; end
          end else begin
            if (m_ptr) begin m_ba[m_c][15:8] = bus_wdata; m_ca[m_c][15:8] = bus_wdata; end
            else       begin m_ba[m_c][7:0]  = bus_wdata; m_ca[m_c][7:0]  = bus_wdata; end
          end
        end
        m_ptr = !m_ptr;
      end
      if (m_w) begin
        case (m_a)
          8:  m_cmd = bus_wdata;
          9:  m_req[bus_wdata % 4] = bus_wdata[2];
          10: m_mask[bus_wdata % 4] = bus_wdata[2];
          11: m_md[bus_wdata % 4] = bus_wdata[7:2];
          12: m_ptr = 0;
          13: begin m_mask = 4'hF; m_cmd = 0; m_req = 0; m_tc = 0; m_ptr = 0; end
          14: m_mask = 0;
          15: m_mask = bus_wdata[3:0];
          default: ;
        endcase
      end
    end
    #2;
    if (rst_n && !done) begin
      chk("R6/R7 mask", 68'(ch_mask), 68'(m_mask));
      chk("R9 cmd", 68'(ctl_cmd), 68'(m_cmd));
      chk("R9 req", 68'(ch_req), 68'(m_req));
      chk("R5/R10/R11 rdata", 68'(bus_rdata), 68'(exp_rdata()));
      for (int i = 0; i < 4; i++) begin
        chk("R2 base_addr", 68'(ch_base_addr[i*16 +: 16]), 68'(m_ba[i]));
        chk("R2 base_cnt",  68'(ch_base_cnt[i*16 +: 16]),  68'(m_bc[i]));
        chk("R13 cur_addr", 68'(ch_cur_addr[i*16 +: 16]),  68'(m_ca[i]));
        chk("R13 cur_cnt",  68'(ch_cur_cnt[i*16 +: 16]),   68'(m_cc[i]));
        chk("R8 mode",      68'(ch_mode[i*6 +: 6]),        68'(m_md[i]));
        chk("R12 len",      68'(ch_len[i*17 +: 17]),       68'(m_cc[i]) + 68'd1);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic bwr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_wr = 0;
  endtask

  task automatic brd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_rd = 1; bus_wr = 0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_cs = 0; bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", 68'(ch_mask), 68'hF);
    chk("R1 cmd", 68'(ctl_cmd), 0);
    chk("R1 addr", 68'(ch_base_addr), 0);
    brd(5'h08, d); chk("R1 status", 68'(d), 0);

    // R2 low then high byte, ch0 address
    bwr(5'h00, 8'h34); bwr(5'h00, 8'h12);
    chk("R2 ch0 base", 68'(ch_base_addr[15:0]), 68'h1234);
    chk("R2 ch0 cur", 68'(ch_cur_addr[15:0]), 68'h1234);
    // R2/R12 ch2 count
    bwr(5'h05, 8'hFF); bwr(5'h05, 8'h00);
    chk("R2 ch2 cnt", 68'(ch_base_cnt[47:32]), 68'h00FF);
    chk("R12 ch2 len", 68'(ch_len[50:34]), 68'd256);

    // R3 pointer shared between registers
    bwr(5'h02, 8'hAA); bwr(5'h07, 8'hBB);
    chk("R3 ch1 addr lo", 68'(ch_base_addr[31:16]), 68'h00AA);
    chk("R3 ch3 cnt hi", 68'(ch_base_cnt[63:48]), 68'hBB00);

    // R4 clear pointer mid-pair
    bwr(5'h00, 8'h11); bwr(5'h0C, 8'h5A); bwr(5'h00, 8'h22);
    chk("R4 ch0 addr", 68'(ch_base_addr[15:0]), 68'h1222);
    bwr(5'h0C, 8'h00);

    // R5 readback through pointer
    brd(5'h00, d); chk("R5 lo", 68'(d), 68'h22);
    brd(5'h00, d); chk("R5 hi", 68'(d), 68'h12);
    brd(5'h0A, d); chk("R5 write-only", 68'(d), 0);
    brd(5'h15, d); chk("R5 unmapped", 68'(d), 0);

    // R6 single mask, R7 group masks
    bwr(5'h0E, 8'hFF); chk("R7 clrmask", 68'(ch_mask), 0);
    bwr(5'h0A, 8'h06); chk("R6 set ch2", 68'(ch_mask), 68'h4);
    bwr(5'h0A, 8'h05); chk("R6 set ch1", 68'(ch_mask), 68'h6);
    bwr(5'h0A, 8'h02); chk("R6 clr ch2", 68'(ch_mask), 68'h2);
    bwr(5'h0F, 8'hF9); chk("R7 allmask", 68'(ch_mask), 68'h9);

    // R8 mode
    bwr(5'h0B, 8'h56); chk("R8 ch2 mode", 68'(ch_mode[17:12]), 68'h15);
    bwr(5'h0B, 8'h48); chk("R8 ch0 mode", 68'(ch_mode[5:0]), 68'h12);

    // R9 command and request
    bwr(5'h08, 8'hC4); chk("R9 cmd", 68'(ctl_cmd), 68'hC4);
    bwr(5'h09, 8'h07); chk("R9 req", 68'(ch_req), 68'h8);

    // R13 engine update, reload with auto-initialise
    @(negedge clk);
    eng_upd_valid = 1; eng_upd_ch = 2; eng_upd_addr = 16'hBEEF; eng_upd_cnt = 16'h0010;
    @(negedge clk);
    eng_upd_valid = 0;
    chk("R13 upd cur", 68'(ch_cur_addr[47:32]), 68'hBEEF);
    chk("R13 base kept", 68'(ch_base_addr[47:32]), 0);
    eng_tc = 4'b0101;
    @(negedge clk);
    eng_tc = 0;
    chk("R13 reload cnt", 68'(ch_cur_cnt[47:32]), 68'h00FF);
    chk("R13 no autoinit ch0", 68'(ch_cur_addr[15:0]), 68'h1222);

    // R10 status and read-clear, pulse coinciding with read
    @(negedge clk);
    bus_cs = 1; bus_rd = 1; bus_addr = 5'h08; eng_tc = 4'b0010;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_cs = 0; bus_rd = 0; eng_tc = 0;
    chk("R10 status", 68'(d), 68'h85);
    brd(5'h08, d); chk("R10 after clear", 68'(d), 68'h82);

    // R12 extremes
    bwr(5'h03, 8'hFF); bwr(5'h03, 8'hFF);
    chk("R12 max", 68'(ch_len[33:17]), 68'd65536);
    bwr(5'h03, 8'h00); bwr(5'h03, 8'h00);
    chk("R12 min", 68'(ch_len[33:17]), 68'd1);

    // R5 write takes precedence when both strobes are set
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_rd = 1; bus_addr = 5'h08; bus_wdata = 8'h3C;
    #2 chk("R5 wr+rd rdata", 68'(bus_rdata), 0);
    @(negedge clk);
    bus_cs = 0; bus_wr = 0; bus_rd = 0;
    chk("R5 wr+rd cmd", 68'(ctl_cmd), 68'h3C);

    // R11 master clear with pointer on high byte, temp read
    bwr(5'h00, 8'h77);
    bwr(5'h0D, 8'h00);
    chk("R11 mask", 68'(ch_mask), 68'hF);
    chk("R11 cmd", 68'(ctl_cmd), 0);
    chk("R11 req", 68'(ch_req), 0);
    chk("R11 addr kept", 68'(ch_base_addr[15:0]), 68'h1277);
    chk("R11 mode kept", 68'(ch_mode[17:12]), 68'h15);
    bwr(5'h00, 8'h99);
    chk("R11 ptr low", 68'(ch_base_addr[15:0]), 68'h1299);
    eng_temp = 8'h5A;
    brd(5'h0D, d); chk("R11 temp", 68'(d), 68'h5A);

    idle(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule